// File: doc/BRIEF.md
# Toggle-Ring Pseudo-Random Scan Pattern Source

This block supplies pseudo-random bits to the scan chains of a logic self-test. It holds several identical rings of storage cells. Each cell either copies its upstream neighbour or folds that neighbour into its own value with an exclusive-or. There is no separate feedback tap network and no mixing stage on the outputs. Every scan bit comes straight from a cell that can act as a toggle cell.

A parameter mask picks which ring positions hold configurable cells. One mode input switches all of those cells at the same time. With the mode low they act as plain copy cells, and each ring becomes a circular shift register that can be seeded or read back. With the mode high they act as toggle cells. Each ring then runs through the full maximal-length sequence of its characteristic polynomial, and every ring uses the same polynomial.

A seed load writes all rings in one cycle. Each ring gets the seed rotated by its own amount, so the rings start at different points of the shared sequence. A seed of zero would leave a ring stuck, so the block replaces it with a fixed nonzero value.

Top module: `dtr_prpg`

## Requirements
- R1: After reset, ring r holds the value 1 rotated left by (r*PHASE_STEP) mod RING_LEN. With the defaults (RING_LEN=7, 4 rings, PHASE_STEP=2), the rings hold 1, 4, 16 and 64.
- R2: When `seed_load` is high at a clock edge, it overrides `advance` and `toggle_mode`. Ring r then holds `seed` rotated left by (r*PHASE_STEP) mod RING_LEN, where a left rotation moves bit i to bit i+amount, wrapping around.
- R3: A `seed` of zero is replaced by the value 1 before the rotation, so loading zero gives the same ring contents as reset.
- R4: With `seed_load` and `advance` both low, every ring keeps its state, whatever `toggle_mode` is.
- R5: With `advance` high and `toggle_mode` low, every cell copies its upstream neighbour: bit i takes bit i-1, and bit 0 takes bit RING_LEN-1.
- R6: With `advance` high and `toggle_mode` high, each cell at a position whose bit is set in T_MASK takes its own value XOR bit i-1. Every other cell copies bit i-1. The default T_MASK sets positions 0, 2 and 5.
- R7: `scan_bits[r*K+j]` is bit p_j of ring r. Here K is the number of configurable positions, and p_j is the j-th lowest set position of T_MASK. With the defaults, K=3 and the positions are 0, 2 and 5.
- R8: In toggle mode, every ring with the default parameters returns to its start state after exactly 127 steps, and no state repeats within those steps.
- R9: No ring ever holds the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Writes the seed into all rings at the next edge |
| seed | input | RING_LEN | Seed value, rotated per ring |
| advance | input | 1 | Steps all rings by one cycle |
| toggle_mode | input | 1 | 1: configurable cells toggle; 0: they copy |
| scan_bits | output | RING_CNT*K | Bits taken from the configurable cells, ring-major |

## Verification
Every output bit is a cell output with no logic after it. A load or a step applied at one rising edge therefore shows up on `scan_bits` just after that same edge, with a latency of one cycle and no pipeline. The bench changes inputs on the falling edge and pushes the value it expects for the next rising edge into a queue. A monitor pops that value 1 ns after the rising edge and compares it. A full 127-step run is followed by a copy-mode shift of seven cycles. That shift moves every ring bit past the tap positions, which shows the whole ring state at the ports.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  localparam int unsigned MASK_W = 64;

  // number of set bits among the low len positions
  function automatic int unsigned mask_ones(input logic [MASK_W-1:0] m, input int unsigned len);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < MASK_W; i++)
      if (i < len && m[i]) c++;
    return c;
  endfunction

  // position of the j-th lowest set bit among the low len positions
  function automatic int unsigned mask_pos(input logic [MASK_W-1:0] m, input int unsigned len,
                                           input int unsigned j);
    int unsigned seen;
    int unsigned pos;
    seen = 0;
    pos  = 0;
    for (int unsigned i = 0; i < MASK_W; i++)
      if (i < len && m[i]) begin
        if (seen == j) pos = i;
        seen++;
      end
    return pos;
  endfunction
endpackage

// File: rtl/dtr_cell.sv
module dtr_cell #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_val,
  input  logic en,
  input  logic toggle,
  input  logic prev,
  output logic q
);
  logic nxt;

  always_comb nxt = toggle ? (q ^ prev) : prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (load) q <= load_val;
    else if (en)   q <= nxt;
  end
endmodule

// File: rtl/dtr_seed_fix.sv
module dtr_seed_fix #(
  parameter int unsigned N = 7
) (
  input  logic [N-1:0] seed,
  output logic [N-1:0] seed_nz,
  output logic         zero_seen
);
  always_comb begin
    zero_seen = (seed == '0);
    seed_nz   = zero_seen ? N'(1) : seed;
  end
endmodule

// File: rtl/dtr_ring.sv
module dtr_ring #(
  parameter int unsigned N    = 7,
  parameter logic [63:0] MASK = 64'h25,
  parameter int unsigned ROT  = 0,
  parameter int unsigned K    = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] seed_nz,
  input  logic         en,
  input  logic         mode,
  output logic [N-1:0] state,
  output logic [K-1:0] taps
);
  function automatic logic [N-1:0] rot_n(input logic [N-1:0] v, input int unsigned amt);
    logic [N-1:0] r;
    for (int unsigned i = 0; i < N; i++) r[(i + amt) % N] = v[i];
    return r;
  endfunction

  function automatic logic [N-1:0] step_n(input logic [N-1:0] v, input logic tm);
    logic [N-1:0] r;
    for (int unsigned i = 0; i < N; i++)
      r[i] = (tm && MASK[i]) ? (v[i] ^ v[(i + N - 1) % N]) : v[(i + N - 1) % N];
    return r;
  endfunction

  localparam logic [N-1:0] RST_IMG = rot_n(N'(1), ROT);

  logic [N-1:0] load_img;
  logic [N-1:0] tog;
  logic [N-1:0] exp_toggle;
  logic [N-1:0] exp_shift;
  logic         step_fire;

  assign load_img   = rot_n(seed_nz, ROT);
  assign step_fire  = en && !load;
  assign exp_toggle = step_n(state, 1'b1);
  assign exp_shift  = rot_n(state, 1);

  for (genvar i = 0; i < N; i++) begin : g_cell
    localparam int unsigned UP = (i + N - 1) % N;
    if (MASK[i]) begin : g_cfg
      assign tog[i] = mode;
    end else begin : g_fix
      assign tog[i] = 1'b0;
    end
    dtr_cell #(.RST_VAL(RST_IMG[i])) u_cell (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_img[i]),
      .en(en), .toggle(tog[i]), .prev(state[UP]), .q(state[i])
    );
  end

  for (genvar j = 0; j < K; j++) begin : g_tap
    assign taps[j] = state[dtr_pkg::mask_pos(MASK, N, j)];
  end

  // R9
  ring_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) state != '0);
  // R4
  ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !en) |=> $stable(state));
  // R2
  ring_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state == $past(load_img));
  // R5
  ring_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !mode) |=> state == $past(exp_shift));
  // R6
  ring_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && mode) |=> state == $past(exp_toggle));
endmodule

// File: rtl/dtr_prpg.sv
module dtr_prpg #(
  parameter int unsigned RING_LEN   = 7,
  parameter int unsigned RING_CNT   = 4,
  parameter logic [63:0] T_MASK     = 64'h25,
  parameter int unsigned PHASE_STEP = 2,
  localparam int unsigned K = dtr_pkg::mask_ones(T_MASK, RING_LEN)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  seed_load,
  input  logic [RING_LEN-1:0]   seed,
  input  logic                  advance,
  input  logic                  toggle_mode,
  output logic [RING_CNT*K-1:0] scan_bits
);
  logic [RING_LEN-1:0] seed_nz;
  logic                zero_seen;
  logic [RING_LEN-1:0] ring_state [RING_CNT];

  dtr_seed_fix #(.N(RING_LEN)) u_fix (
    .seed(seed), .seed_nz(seed_nz), .zero_seen(zero_seen)
  );

  for (genvar r = 0; r < RING_CNT; r++) begin : g_ring
    dtr_ring #(
      .N(RING_LEN), .MASK(T_MASK), .ROT((r * PHASE_STEP) % RING_LEN), .K(K)
    ) u_ring (
      .clk(clk), .rst_n(rst_n), .load(seed_load), .seed_nz(seed_nz),
      .en(advance), .mode(toggle_mode), .state(ring_state[r]),
      .taps(scan_bits[r*K +: K])
    );
  end

  // R3
  zero_seed_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && zero_seen) |=> ring_state[0] == RING_LEN'(1));
  // R2
  seed_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && !zero_seen) |=> ring_state[0] == $past(seed));
endmodule

// File: tb/dtr_prpg_bench.sv
module dtr_prpg_bench;
  localparam int N = 7;
  localparam int RC = 4;
  localparam int K = 3;
  localparam int TP [K] = '{0, 2, 5};
  localparam logic [N-1:0] TM = 7'b0100101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed_load = 1'b0;
  logic [N-1:0] seed = '0;
  logic advance = 1'b0;
  logic toggle_mode = 1'b0;
  logic [RC*K-1:0] scan_bits;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] mdl [RC];
  logic [RC*K-1:0] exp_q [$];
  string tag_q [$];

  always #2 clk = ~clk;

  dtr_prpg u_dtr_prpg (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
    .advance(advance), .toggle_mode(toggle_mode), .scan_bits(scan_bits)
  );

  function automatic logic [N-1:0] rotl(input logic [N-1:0] v, input int a);
    logic [2*N-1:0] w;
    w = {v, v} << a;
    return w[2*N-1:N];
  endfunction

  function automatic logic [RC*K-1:0] taps_of();
    logic [RC*K-1:0] t;
    for (int r = 0; r < RC; r++)
      for (int j = 0; j < K; j++) t[r*K+j] = mdl[r][TP[j]];
    return t;
  endfunction

  task automatic check(input string tag, input logic [RC*K-1:0] act, input logic [RC*K-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ld, input logic [N-1:0] sd, input logic adv, input logic tm,
                       input string tag);
    @(negedge clk);
    seed_load = ld; seed = sd; advance = adv; toggle_mode = tm;
    for (int r = 0; r < RC; r++) begin
      logic [N-1:0] o;
      o = mdl[r];
      if (ld) mdl[r] = rotl((sd == 0) ? N'(1) : sd, (r*2) % N);
      else if (adv)
        for (int i = 0; i < N; i++) begin
          logic up;
          up = o[(i == 0) ? N-1 : i-1];
          mdl[r][i] = (tm && TM[i]) ? (o[i] ^ up) : up;
        end
    end
    exp_q.push_back(taps_of());
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), scan_bits, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen [128];
    logic [N-1:0] start0;
    bit rep;
    logic zero_hit;
    for (int r = 0; r < RC; r++) mdl[r] = rotl(N'(1), (r*2) % N);
    repeat (3) @(negedge clk);
    // R1 reset contents, seen through the R7 taps
    check("R1", scan_bits, taps_of());
    check("R7", scan_bits, 12'h011);
    rst_n = 1'b1;
    // R2 load wins over advance and toggle mode
    drive(1'b1, 7'h35, 1'b1, 1'b1, "R2");
    // R4 hold in both modes
    drive(1'b0, 7'h00, 1'b0, 1'b1, "R4");
    drive(1'b0, 7'h00, 1'b0, 1'b0, "R4");
    drive(1'b0, 7'h7f, 1'b0, 1'b1, "R4");
    // R5 copy-mode rotation
    for (int c = 0; c < 9; c++) drive(1'b0, 7'h00, 1'b1, 1'b0, "R5");
    // R3 zero seed replaced
    drive(1'b1, 7'h00, 1'b0, 1'b0, "R3");
    drive(1'b0, 7'h00, 1'b1, 1'b1, "R6");
    drive(1'b1, 7'h4b, 1'b0, 1'b0, "R2");
    // R6 / R8 full period in toggle mode
    start0 = mdl[0];
    rep = 1'b0;
    zero_hit = 1'b0;
    for (int s = 0; s < 128; s++) seen[s] = 1'b0;
    seen[start0] = 1'b1;
    for (int c = 0; c < 127; c++) begin
      drive(1'b0, 7'h00, 1'b1, 1'b1, (c < 20) ? "R6" : "R8");
      if (c < 126) begin
        if (seen[mdl[0]]) rep = 1'b1;
        seen[mdl[0]] = 1'b1;
      end
      for (int r = 0; r < RC; r++) if (mdl[r] == 0) zero_hit = 1'b1;
    end
    checks++;
    if (rep || mdl[0] != start0) begin
      errors++;
      $display("FAIL R8 actual repeat=%0d end=%h expected repeat=0 end=%h", rep, mdl[0], start0);
    end
    checks++;
    if (zero_hit) begin
      errors++;
      $display("FAIL R9 actual zero state expected nonzero");
    end
    // R5 readback of full ring state after the period (R9: nonzero states visible)
    for (int c = 0; c < 7; c++) drive(1'b0, 7'h00, 1'b1, 1'b0, "R5");
    drive(1'b0, 7'h00, 1'b0, 1'b0, "R4");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule